// File: doc/BRIEF.md
# Reloading interval timer channel

This block is one down-counting timer channel. It produces periodic interrupts and a square wave. Software programs a 16-bit period value. It picks one of four externally generated count-enable strobes and sets the starting level and enable of the waveform pin. It then launches the channel with a self-clearing start trigger. While the channel runs, the counter steps down once per selected strobe. On the strobe after it reaches zero, it reloads the period, raises a one-cycle interrupt and inverts the waveform, so each half-period spans period+1 strobes.

A stop trigger freezes the counter and the waveform level where they are. The period may be rewritten while the channel runs, and the new value is picked up at the next reload. An optional mode makes the start itself raise an interrupt and invert the waveform. All control inputs are one-cycle strobes sampled on the rising clock edge. The reset is synchronous and active high.

Top module: `ivt_channel`

## Requirements
- R1: After reset, `count` is 0, `running` is 0, `irq` is 0 and `wave` is 0. The period, the clock select, the start-interrupt mode, the level and the output enable are all 0.
- R2: A `start_trig` pulse without `stop_trig` sets `running` to 1 at that edge and loads `count` with the period register as it stood before that edge.
- R3: When the start-interrupt mode bit is 1, the start edge also raises `irq` for one cycle and inverts the output level. When the bit is 0, the start raises no interrupt and leaves the level unchanged.
- R4: While running, each edge on which the selected strobe is high decrements `count` by 1. If `count` is 0 on such an edge, it instead reloads the period, raises `irq` for that cycle and inverts the output level.
- R5: A `stop_trig` pulse clears `running`. `count` and the level keep their values. If `start_trig` and `stop_trig` arrive together, stop wins and no load or interrupt occurs.
- R6: A period write while running leaves the current count untouched and takes effect at the next reload.
- R7: `mode_clk_sel` (index 0 to 3) selects which bit of `tick_en` drives counting, and the other bits have no effect. Mode writes are accepted only while stopped.
- R8: A `level_we` write sets the output level only while stopped. While running it is ignored.
- R9: `wave` equals the output level when the output enable is 1, and is 0 otherwise.
- R10: A start while already running reloads `count` from the period and restarts the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 4 | Prescaled count-enable strobes |
| period_we | input | 1 | Period write strobe |
| period_wdata | input | 16 | Period value |
| mode_we | input | 1 | Mode write strobe (stopped only) |
| mode_clk_sel | input | 2 | Index of the count-enable strobe |
| mode_start_irq | input | 1 | 1: interrupt and invert at start |
| level_we | input | 1 | Output level write strobe (stopped only) |
| level_wdata | input | 1 | Output level value |
| oe_we | input | 1 | Output enable write strobe |
| oe_wdata | input | 1 | Output enable value |
| start_trig | input | 1 | Start trigger pulse |
| stop_trig | input | 1 | Stop trigger pulse |
| count | output | 16 | Current counter value |
| running | output | 1 | Channel is counting |
| irq | output | 1 | One-cycle interrupt pulse |
| wave | output | 1 | Square-wave output |

## Verification
The bench rewrites the period in the middle of an interval. A design that reloaded at once would shorten that interval and put the next interrupt in the wrong cycle. It also pulses start and stop together, where a design that favoured start would reload the counter and, with the start-interrupt mode on, fire an unexpected interrupt. It leaves the unselected strobes active, which would make a design that counted on any of them drift. It writes the level while running, where a design that accepted the write would flip the pin without an interrupt. Every interrupt is matched against a queue of predicted cycle numbers, so an off-by-one half-period shows up as a mismatch.

// File: rtl/ivt_channel.sv
module ivt_channel #(
  parameter int CW   = 16,
  parameter int NSEL = 4,
  localparam int SW  = (NSEL > 1) ? $clog2(NSEL) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NSEL-1:0] tick_en,
  input  logic          period_we,
  input  logic [CW-1:0] period_wdata,
  input  logic          mode_we,
  input  logic [SW-1:0] mode_clk_sel,
  input  logic          mode_start_irq,
  input  logic          level_we,
  input  logic          level_wdata,
  input  logic          oe_we,
  input  logic          oe_wdata,
  input  logic          start_trig,
  input  logic          stop_trig,
  output logic [CW-1:0] count,
  output logic          running,
  output logic          irq,
  output logic          wave
);

  logic [CW-1:0] period_q, cnt_q;
  logic [SW-1:0] sel_q;
  logic          sirq_q, lvl_q, oe_q, run_q, irq_q;
  logic          tick_sel;

  assign tick_sel = tick_en[sel_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      cnt_q    <= '0;
      sel_q    <= '0;
      sirq_q   <= 1'b0;
      lvl_q    <= 1'b0;
      oe_q     <= 1'b0;
      run_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (period_we) period_q <= period_wdata;
      if (oe_we) oe_q <= oe_wdata;
      if (mode_we && !run_q) begin
        sel_q  <= mode_clk_sel;
        sirq_q <= mode_start_irq;
      end
      if (stop_trig) begin
        run_q <= 1'b0;
      end else if (start_trig) begin
        run_q <= 1'b1;
        cnt_q <= period_q;
        if (sirq_q) begin
          irq_q <= 1'b1;
          lvl_q <= ~lvl_q;
        end
      end else if (run_q && tick_sel) begin
        if (cnt_q == '0) begin
          cnt_q <= period_q;
          irq_q <= 1'b1;
          lvl_q <= ~lvl_q;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end else if (!run_q && level_we) begin
        lvl_q <= level_wdata;
      end
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
  assign irq     = irq_q;
  assign wave    = oe_q & lvl_q;

endmodule

// File: rtl/ivt_channel_chk.sv
module ivt_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start_trig,
  input logic          stop_trig,
  input logic          tick_sel,
  input logic [CW-1:0] period_q,
  input logic          lvl_q,
  input logic [CW-1:0] count,
  input logic          running,
  input logic          irq
);

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (start_trig && !stop_trig) |=> (running && count == $past(period_q)));

  p_stop_wins_r5: assert property (@(posedge clk) disable iff (rst)
    stop_trig |=> (!running && count == $past(count) && lvl_q == $past(lvl_q)));

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (running && !start_trig && !stop_trig && tick_sel && count != '0)
      |=> (count == $past(count) - CW'(1) && !irq));

  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (running && !start_trig && !stop_trig && tick_sel && count == '0)
      |=> (irq && count == $past(period_q)));

  p_irq_toggles_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> (lvl_q != $past(lvl_q)));

  p_idle_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (running && !start_trig && !stop_trig && !tick_sel) |=> ($stable(count) && !irq));

endmodule

bind ivt_channel ivt_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start_trig(start_trig), .stop_trig(stop_trig),
  .tick_sel(tick_sel), .period_q(period_q), .lvl_q(lvl_q),
  .count(count), .running(running), .irq(irq)
);

// File: tb/tb_ivt_channel.sv
`timescale 1ns/1ps
module tb_ivt_channel;
  logic clk = 1'b0;
  logic rst;
  logic [3:0] tick_en;
  logic period_we, mode_we, mode_start_irq, level_we, level_wdata;
  logic oe_we, oe_wdata, start_trig, stop_trig;
  logic [15:0] period_wdata;
  logic [1:0] mode_clk_sel;
  logic [15:0] count;
  logic running, irq, wave;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  int exp_q[$];
  int e0, s1, s2;

  ivt_channel dut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .period_we(period_we), .period_wdata(period_wdata),
    .mode_we(mode_we), .mode_clk_sel(mode_clk_sel), .mode_start_irq(mode_start_irq),
    .level_we(level_we), .level_wdata(level_wdata),
    .oe_we(oe_we), .oe_wdata(oe_wdata),
    .start_trig(start_trig), .stop_trig(stop_trig),
    .count(count), .running(running), .irq(irq), .wave(wave)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every interrupt pops the next predicted cycle
  always @(negedge clk) begin
    if (!rst && irq) begin
      if (exp_q.size() == 0) chk("R4 unexpected irq", cyc, 32'hFFFF_FFFF);
      else chk("R3/R4 irq cycle", cyc, exp_q.pop_front());
    end
  end

  task automatic nxt(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    period_we = 0; mode_we = 0; level_we = 0; oe_we = 0;
    start_trig = 0; stop_trig = 0;
  endtask

  initial begin
    rst = 1; tick_en = 4'b0001; period_wdata = 0; mode_clk_sel = 0;
    mode_start_irq = 0; level_wdata = 0; oe_wdata = 0; clr();
    nxt(3);
    rst = 0;
    chk("R1 count", count, 0);
    chk("R1 running", running, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wave", wave, 0);

    period_we = 1; period_wdata = 16'd3;
    mode_we = 1; mode_clk_sel = 2'd0; mode_start_irq = 0;
    oe_we = 1; oe_wdata = 1; level_we = 1; level_wdata = 0;
    nxt(); clr();
    chk("R9 wave low level", wave, 0);

    start_trig = 1; e0 = cyc + 1;
    exp_q.push_back(e0 + 4); exp_q.push_back(e0 + 8); exp_q.push_back(e0 + 14);
    nxt(); clr();
    chk("R2 running", running, 1);
    chk("R2 count load", count, 3);
    chk("R3 no start irq", irq, 0);
    nxt();
    chk("R4 decrement", count, 2);
    nxt(3);
    chk("R4 reload", count, 3);
    chk("R4 toggle", wave, 1);
    nxt();
    period_we = 1; period_wdata = 16'd5;
    nxt(); clr();
    chk("R6 current count kept", count, 1);
    nxt(2);
    chk("R6 new period at reload", count, 5);
    chk("R4 toggle back", wave, 0);
    nxt(7);
    chk("R6 count", count, 4);
    stop_trig = 1;
    nxt(); clr();
    chk("R5 running cleared", running, 0);
    chk("R5 count held", count, 4);
    chk("R5 level held", wave, 1);
    nxt(5);
    chk("R5 count frozen", count, 4);

    level_we = 1; level_wdata = 0;
    nxt(); clr();
    chk("R8 level write stopped", wave, 0);
    level_we = 1; level_wdata = 1; oe_we = 1; oe_wdata = 0;
    nxt(); clr();
    chk("R9 oe off", wave, 0);
    oe_we = 1; oe_wdata = 1;
    nxt(); clr();
    chk("R9 oe on", wave, 1);

    mode_we = 1; mode_clk_sel = 2'd1; mode_start_irq = 1;
    nxt(); clr();
    start_trig = 1; s1 = cyc + 1; exp_q.push_back(s1);
    nxt(); clr();
    chk("R3 running", running, 1);
    chk("R3 count", count, 5);
    chk("R3 start toggle", wave, 0);
    nxt(4);
    chk("R7 unselected strobe ignored", count, 5);
    tick_en = 4'b0010;
    nxt(2);
    chk("R7 selected strobe counts", count, 3);
    level_we = 1; level_wdata = 1;
    nxt(); clr();
    chk("R8 level write ignored running", wave, 0);
    start_trig = 1; s2 = cyc + 1; exp_q.push_back(s2);
    nxt(); clr();
    chk("R10 restart reload", count, 5);
    chk("R10 running", running, 1);
    chk("R10 start toggle", wave, 1);
    nxt();
    chk("R10 count", count, 4);
    start_trig = 1; stop_trig = 1;
    nxt(); clr();
    chk("R5 stop wins running", running, 0);
    chk("R5 stop wins count", count, 4);
    nxt(3);
    chk("R5 count after stop", count, 4);
    chk("R4 all irqs seen", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule